// File: doc/BRIEF.md
# Parallel-Capture Serial-Output Shift Register

An eight-stage shift register held in one system-clock domain. Every external pin passes through a synchroniser. While the mode pin is low, the register follows the parallel byte continuously. While the mode pin is high, the register advances by one stage on each shift strobe, and the serial pin fills the entry stage. The strobe is the rising edge of the OR of two strobe pins. Either pin can therefore act as the strobe, or as an active-high gate on the other pin.

The last stage is presented on a true output and on an inverted output. Several registers can be chained by wiring one register's true output to the next register's serial input. With no strobe the register holds its contents for as long as needed.

Top module: `piso_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage, so `q_o` reads 0 and `q_n_o` reads 1 while reset is held.
- R2: While `load_n_i` is low, all stages copy `par_i` continuously without any strobe. Bit 0 of `par_i` feeds the entry stage and bit 7 feeds the last stage, which `q_o` shows. The result appears 3 system cycles after the pins change.
- R3: While `load_n_i` is high, each strobe moves every stage one place toward the last stage and places `ser_i` in the entry stage. `q_o` updates 3 system cycles after the strobe pin rises.
- R4: The strobe is a 0-to-1 change of `clk_a_i | clk_b_i` after synchronisation. A pin that rises while the other pin is low gives one strobe. A pin that rises or falls while the other pin is high gives none.
- R5: Strobes that arrive while `load_n_i` is low do not shift the register.
- R6: A strobe seen in the same system cycle as the first high sample of `load_n_i` is dropped, so the loaded last-stage bit is presented first.
- R7: Without a strobe and with `load_n_i` high, the contents and outputs hold indefinitely.
- R8: `q_n_o` is always the inverse of `q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n_i | input | 1 | Mode pin: low captures the parallel byte, high enables shifting |
| clk_a_i | input | 1 | Strobe pin A |
| clk_b_i | input | 1 | Strobe pin B, interchangeable with A |
| ser_i | input | 1 | Serial data into the entry stage |
| par_i | input | STAGES (8) | Parallel data; bit 0 is the entry stage, bit 7 is the last stage |
| q_o | output | 1 | Last stage |
| q_n_o | output | 1 | Inverse of the last stage |

## Verification
Each result is due on the third system edge after the pin change that causes it. Two of those edges belong to the synchroniser and the third is the stage update. The driver changes pins on a falling edge and waits three rising edges. It then queues the expected last-stage bit, and the monitor compares it on the following falling edge. Stimuli that must have no effect, such as a held-high gate, a falling strobe, a strobe during load or a strobe at load release, get the same three-edge wait. After that wait the unchanged bit is queued, so a wrongly taken shift shows up on the output before the next stimulus.

// File: rtl/piso_shift_reg.sv
module piso_shift_reg #(
  parameter int STAGES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n_i,
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              ser_i,
  input  logic [STAGES-1:0] par_i,
  output logic              q_o,
  output logic              q_n_o
);
  localparam int BUSW = STAGES + 4;

  logic [BUSW-1:0] raw;
  logic [BUSW-1:0] sync_q [SYNC_STAGES];
  logic [BUSW-1:0] s;
  logic            shift_md, strobe_lvl, ser_s;
  logic [STAGES-1:0] par_s;
  logic            strobe_d, mode_d, rise, shift_go;
  logic [STAGES-1:0] stg;

  assign raw = {load_n_i, clk_a_i, clk_b_i, ser_i, par_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s          = sync_q[SYNC_STAGES-1];
  assign shift_md   = s[BUSW-1];
  assign strobe_lvl = s[BUSW-2] | s[BUSW-3];
  assign ser_s      = s[STAGES];
  assign par_s      = s[STAGES-1:0];
  assign rise       = strobe_lvl & ~strobe_d;
  assign shift_go   = shift_md & mode_d & rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_d <= 1'b0;
      mode_d   <= 1'b0;
      stg      <= '0;
    end else begin
      strobe_d <= strobe_lvl;
      mode_d   <= shift_md;
      if (!shift_md)     stg <= par_s;
      else if (shift_go) stg <= {stg[STAGES-2:0], ser_s};
    end
  end

  assign q_o   = stg[STAGES-1];
  assign q_n_o = ~stg[STAGES-1];

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q_o == 1'b0)); // R1
  AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !shift_md |=> (stg == $past(par_s))); // R2
  AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    shift_go |=> (q_o == $past(stg[STAGES-2]))); // R3
  AST_HELD_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (shift_md && mode_d && strobe_lvl && strobe_d) |=> $stable(stg)); // R4
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (shift_md && !mode_d) |=> $stable(stg)); // R6
  AST_STATIC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (shift_md && !rise) |=> $stable(stg)); // R7
endmodule

// File: tb/test_piso_shift_reg.sv
module test_piso_shift_reg;
  localparam int STAGES = 8;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_n = 1'b0, ca = 1'b0, cb = 1'b0, ser = 1'b0;
  logic [STAGES-1:0] par = '0;
  logic q, qn;

  always #2 clk = ~clk;

  piso_shift_reg #(.STAGES(STAGES), .SYNC_STAGES(LAT-1)) i_piso_shift_reg (
    .clk(clk), .rst(rst), .load_n_i(load_n), .clk_a_i(ca), .clk_b_i(cb),
    .ser_i(ser), .par_i(par), .q_o(q), .q_n_o(qn));

  typedef struct { logic val; string tag; } exp_t;
  exp_t sb[$];
  int vectors = 0, errs = 0;
  logic [STAGES-1:0] model = '0;
  bit done = 1'b0;

  task automatic push(input logic v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic settle();
    repeat (LAT) @(posedge clk);
  endtask

  task automatic load(input logic [STAGES-1:0] p, input string tag);
    @(negedge clk); par = p; load_n = 1'b0;
    settle(); model = p; push(model[STAGES-1], tag);
  endtask

  task automatic drive_pin(input bit use_b, input logic lvl, input bit shifts,
                           input logic s, input string tag);
    @(negedge clk); ser = s;
    if (use_b) cb = lvl; else ca = lvl;
    settle();
    if (shifts) model = {model[STAGES-2:0], s};
    push(model[STAGES-1], tag);
  endtask

  task automatic pulse(input bit use_b, input logic s, input string tag);
    drive_pin(use_b, 1'b1, 1'b1, s, tag);
    drive_pin(use_b, 1'b0, 1'b0, s, tag);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (q !== e.val) begin
        errs++;
        $display("FAIL %s: q_o=%b expected %b", e.tag, q, e.val);
      end
      vectors++;
      if (qn !== ~e.val) begin
        errs++;
        $display("FAIL R8: q_n_o=%b expected %b", qn, ~e.val);
      end
    end
  end

  initial begin
    logic [STAGES-1:0] pat;
    pat = 8'b0100_1101;
    repeat (4) @(posedge clk);
    push(1'b0, "R1 reset");
    @(negedge clk); rst = 1'b0;
    load(8'hA5, "R2 load A5");
    load(8'h3C, "R2 continuous reload");
    drive_pin(1'b0, 1'b1, 1'b0, 1'b1, "R5 strobe during load");
    drive_pin(1'b0, 1'b0, 1'b0, 1'b1, "R5 strobe fall during load");
    @(negedge clk); load_n = 1'b1; ca = 1'b1; ser = 1'b1;
    settle(); push(model[STAGES-1], "R6 strobe at release");
    drive_pin(1'b0, 1'b0, 1'b0, 1'b1, "R6 fall after release");
    for (int k = 0; k < STAGES; k++) pulse(1'b0, pat[k], "R3 shift pin A");
    pulse(1'b1, 1'b1, "R4 pin B alone strobes");
    drive_pin(1'b0, 1'b1, 1'b1, 1'b0, "R4 pin A rise");
    drive_pin(1'b1, 1'b1, 1'b0, 1'b1, "R4 gate rise while A high");
    drive_pin(1'b0, 1'b0, 1'b0, 1'b1, "R4 A fall while gated");
    drive_pin(1'b1, 1'b0, 1'b0, 1'b1, "R4 gate fall");
    pulse(1'b0, 1'b1, "R4 A strobe after gate");
    for (int k = 0; k < 5; k++) begin
      repeat (20) @(posedge clk);
      push(model[STAGES-1], "R7 static hold");
    end
    load(8'hFF, "R2 load FF");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    push(1'b0, "R1 mid-run reset");
    repeat (2) @(posedge clk);
    while (sb.size() != 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule